// File: doc/BRIEF.md
# Reloadable Interval Timer with Latched Readout

This block is a periodic interval timer that sits on a small byte-wide host bus. A 22-bit counter runs upward from zero at a fixed 33 MHz tick rate. When it reaches a programmable terminal value it returns to zero, keeps counting, and can flag an interrupt. The bus clock runs at either 33 MHz or 66 MHz. A speed-select pin tells the block which rate is in use, and the block halves the tick rate in the fast case.

Software arms the timer by loading the terminal value through three byte registers and then setting the run bit in the control register. The live count is read through four latch registers. Reading the lowest latch register freezes a copy of the whole count, so the following three reads return parts of one consistent value. Each of the three lower latch bytes packs six count bits in a split layout. An interrupt is acknowledged by clearing the interrupt-enable bit and then setting it again.

The sequencer has two states. ST_HALT holds the counter, and ST_RUN lets it advance. The transition go_run (HALT to RUN) is taken when the run bit is set, and it zeroes the counter. The transition go_halt (RUN to HALT) is taken when the run bit is cleared.

Top module: `ivt_timer`

## Requirements
- R1: After reset, all of the following read as zero: the control register, the terminal bytes, the four latch bytes and irq.
- R2: With speed_sel=0, the count is k after k+1 rising edges following the edge that wrote the run bit. The go_run edge zeroes the counter, and each later edge adds one.
- R3: With speed_sel=1, the count advances on every second edge only. It is floor(k/2) after k+1 edges following the run-bit write.
- R4: The count runs 0,1,…,T and then returns to 0, where T is the terminal value. The period is T+1 ticks. With T=0 the count stays at 0.
- R5: Reading latch address 4 captures the live count into a snapshot. Reads at addresses 5, 6 and 7 return that snapshot however many cycles later they come. The snapshot changes only on a read of address 4. Read data appears on bus_rdata one edge after the bus_rd strobe.
- R6: Latch bytes at addresses 4, 5 and 6 carry count bits [5:0], [11:6] and [17:12]. Group bits [4:0] sit at byte bits [4:0], and group bit 5 sits at byte bit 6. Address 7 carries count bits [21:18] in bits [3:0]. All other latch bits read 0.
- R7: The terminal value is written at address 1 (bits [7:0]), address 2 (bits [15:8]) and address 3 (bits [21:16] in the low six bits). It reads back at the same addresses, and bits [7:6] of address 3 read 0.
- R8: Clearing the run bit takes the sequencer to ST_HALT, and the count stays constant from then on.
- R9: A write to any terminal byte while in ST_HALT sets the count to zero.
- R10: When the count wraps while interrupt-enable is 1, the pending flag is set and irq goes high right after the wrap edge. A wrap while interrupt-enable is 0 leaves nothing pending.
- R11: Clearing interrupt-enable drops irq at once and discards the pending flag. Setting the bit again does not raise irq until the next wrap.
- R12: The control register is at address 0. Bit 0 is the run bit and bit 1 is interrupt-enable. Bits [7:2] are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 33 or 66 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 1 | 1 when the bus clock is 66 MHz; halves the tick rate |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the edge after bus_rd |
| irq | output | 1 | Level interrupt: pending flag qualified by interrupt-enable |

## Verification
The counting path is exercised at both tick rates, with one terminal value at the maximum and one small enough to force several wraps. It is also run with a terminal value of zero, which separates a compare on "equal to terminal" from a compare on "past terminal".

Readouts are taken both back to back and with long gaps between the latch-byte reads. Only the gapped reads can show whether the upper bytes come from the snapshot or from the live counter. One long run pushes the count past bit 17, so the bit-6 placement of every group is covered.

Interrupt timing is checked three ways, and each one distinguishes a different fault:
- the first wrap edge, which catches an off-by-one in the terminal compare;
- the acknowledge sequence, which catches a pending flag that survives an acknowledge;
- wraps that happen while interrupt-enable is low, which catch a flag that latches while the interrupt is masked.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TERM0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_TERM1 = 3'd2;
    localparam logic [ADDR_W-1:0] A_TERM2 = 3'd3;
    localparam logic [ADDR_W-1:0] A_LAT0  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LAT1  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LAT2  = 3'd6;
    localparam logic [ADDR_W-1:0] A_LAT3  = 3'd7;

    // Six count bits per readout byte: low five in place, the sixth at bit 6.
    function automatic logic [7:0] pack_grp(input logic [5:0] v);
        return {1'b0, v[5], 1'b0, v[4:0]};
    endfunction

endpackage

// File: rtl/ivt_tick.sv
module ivt_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (!run)
            phase_q <= 1'b0;
        else
            phase_q <= ~phase_q;
    end

    always_comb begin
        tick = run && (fast ? phase_q : 1'b1);
    end
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int CNT_W = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 tick,
    input  logic                 term_wr,
    input  logic [CNT_W-1:0]     term,
    output ivt_pkg::run_state_e  state,
    output logic [CNT_W-1:0]     cnt,
    output logic                 wrap
);
    import ivt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    run_state_e state_nx;

    // Next-state logic: go_run / go_halt
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (run_en)  state_nx = ST_RUN;
            ST_RUN:  if (!run_en) state_nx = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        wrap = tick && (cnt == term);
    end

    // Counter, driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_HALT: if (run_en || term_wr) cnt <= '0;
                ST_RUN:  if (tick)              cnt <= wrap ? '0 : cnt + ONE;
            endcase
        end
    end
endmodule

// File: rtl/ivt_latch.sv
module ivt_latch #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grab,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (grab) snap <= cnt;
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int CNT_W = 22
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       speed_sel,
    input  logic [ivt_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    output logic                       irq
);
    import ivt_pkg::*;

    localparam int HI_W  = CNT_W - 16;
    localparam int GRP_W = 6;
    localparam int N_GRP = 3;
    localparam int TOP_W = CNT_W - GRP_W * N_GRP;

    logic             run_en, irq_en, pend_q;
    logic [CNT_W-1:0] term_q, cnt, snap;
    logic             tick, wrap, term_wr, grab;
    run_state_e       state;
    logic [7:0]       lat_byte [0:N_GRP];

    assign term_wr = bus_wr && (bus_addr == A_TERM0 || bus_addr == A_TERM1 ||
                                bus_addr == A_TERM2);
    assign grab    = bus_rd && (bus_addr == A_LAT0);

    ivt_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RUN),
        .fast  (speed_sel),
        .tick  (tick)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .tick    (tick),
        .term_wr (term_wr),
        .term    (term_q),
        .state   (state),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    ivt_latch #(.CNT_W(CNT_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .grab  (grab),
        .cnt   (cnt),
        .snap  (snap)
    );

    // Host-writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            irq_en <= 1'b0;
            term_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL:  begin
                    run_en <= bus_wdata[0];
                    irq_en <= bus_wdata[1];
                end
                A_TERM0: term_q[7:0]       <= bus_wdata;
                A_TERM1: term_q[15:8]      <= bus_wdata;
                A_TERM2: term_q[CNT_W-1:16] <= bus_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Pending flag: set on wrap while enabled, discarded while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (!irq_en) pend_q <= 1'b0;
        else if (wrap)    pend_q <= 1'b1;
    end

    assign irq = pend_q & irq_en;

    // Readout bytes: the lowest group shows the live count that is being grabbed
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        if (g == 0) begin : g_live
            assign lat_byte[g] = pack_grp(cnt[g*GRP_W +: GRP_W]);
        end else begin : g_snap
            assign lat_byte[g] = pack_grp(snap[g*GRP_W +: GRP_W]);
        end
    end
    assign lat_byte[N_GRP] = {{(8-TOP_W){1'b0}}, snap[CNT_W-1:GRP_W*N_GRP]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata <= {6'b0, irq_en, run_en};
                A_TERM0: bus_rdata <= term_q[7:0];
                A_TERM1: bus_rdata <= term_q[15:8];
                A_TERM2: bus_rdata <= {{(8-HI_W){1'b0}}, term_q[CNT_W-1:16]};
                A_LAT0:  bus_rdata <= lat_byte[0];
                A_LAT1:  bus_rdata <= lat_byte[1];
                A_LAT2:  bus_rdata <= lat_byte[2];
                A_LAT3:  bus_rdata <= lat_byte[3];
                default: bus_rdata <= 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int CNT_W = 22
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       speed_sel,
    input logic                       bus_rd,
    input logic [ivt_pkg::ADDR_W-1:0] bus_addr,
    input logic                       irq,
    input logic                       irq_en,
    input logic                       pend_q,
    input logic                       run_en,
    input logic                       term_wr,
    input logic                       tick,
    input logic                       wrap,
    input logic [CNT_W-1:0]           cnt,
    input logic [CNT_W-1:0]           term_q,
    input logic [CNT_W-1:0]           snap,
    input ivt_pkg::run_state_e        state
);
    import ivt_pkg::*;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == term_q) |=> (cnt == '0));                        // R4

    AST_FAST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_sel && tick) |=> (!tick || !speed_sel));                  // R3

    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == A_LAT0) |=> $stable(snap));              // R5

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !run_en && !term_wr) |=> $stable(cnt));      // R8

    AST_TERM_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && term_wr) |=> (cnt == '0));                   // R9

    AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wrap));                                      // R10

    AST_ACK_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !pend_q);                                             // R11
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .irq_en    (irq_en),
    .pend_q    (pend_q),
    .run_en    (run_en),
    .term_wr   (term_wr),
    .tick      (tick),
    .wrap      (wrap),
    .cnt       (cnt),
    .term_q    (term_q),
    .snap      (snap),
    .state     (state)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_sel = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ivt_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic write_term(input int t);
        bus_write(3'd1, t[7:0]);
        bus_write(3'd2, t[15:8]);
        bus_write(3'd3, {2'b00, t[21:16]});
    endtask

    function automatic int grp(input logic [7:0] b);
        return int'(b[4:0]) | (int'(b[6]) << 5);
    endfunction

    // Reads the four latch bytes with 'gap' idle cycles after the first; returns the
    // assembled count and the edge index at which byte 0 was sampled.
    task automatic read_count(input int gap, output int val, output int r_edge);
        logic [7:0] b0, b1, b2, b3;
        bus_read(3'd4, b0);
        r_edge = cyc;
        repeat (gap) @(negedge clk);
        bus_read(3'd5, b1);
        bus_read(3'd6, b2);
        bus_read(3'd7, b3);
        check(((b0 | b1 | b2) & 8'hA0) == 0 && (b3 & 8'hF0) == 0, "R6 unused latch bits",
              int'({b3, b2, b1, b0}), 0);
        val = grp(b0) | (grp(b1) << 6) | (grp(b2) << 12) | (int'(b3[3:0]) << 18);
    endtask

    function automatic int exp_count(input int e, input int r, input int term, input bit fast);
        int k = r - e - 2;
        int t = fast ? k / 2 : k;
        return t % (term + 1);
    endfunction

    task automatic wait_irq(output int at);
        while (irq !== 1'b1) @(negedge clk);
        at = cyc;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int v, r;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        bus_read(3'd0, d); check(d == 8'h00, "R1 ctrl after reset", d, 0);
        bus_read(3'd1, d); check(d == 8'h00, "R1 term0 after reset", d, 0);
        bus_read(3'd2, d); check(d == 8'h00, "R1 term1 after reset", d, 0);
        bus_read(3'd3, d); check(d == 8'h00, "R1 term2 after reset", d, 0);
        read_count(0, v, r);
        check(v == 0, "R1 count after reset", v, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_write(3'd0, 8'h02);
        bus_read(3'd0, d); check(d == 8'h02, "R12 ctrl readback", d, 8'h02);
        bus_write(3'd0, 8'hFC);
        bus_read(3'd0, d); check(d == 8'h00, "R12 ctrl upper bits ignored", d, 8'h00);
        bus_write(3'd1, 8'h12);
        bus_write(3'd2, 8'h34);
        bus_write(3'd3, 8'hFF);
        bus_read(3'd1, d); check(d == 8'h12, "R7 term byte 0", d, 8'h12);
        bus_read(3'd2, d); check(d == 8'h34, "R7 term byte 1", d, 8'h34);
        bus_read(3'd3, d); check(d == 8'h3F, "R7 term byte 2 six bits", d, 8'h3F);
    endtask

    task automatic t_slow();
        int e, v, r, x;
        speed_sel = 1'b0;
        bus_write(3'd0, 8'h00);
        write_term(22'h3FFFFF);
        bus_write(3'd0, 8'h01);
        e = cyc;
        repeat (37) @(negedge clk);
        read_count(0, v, r);
        x = exp_count(e, r, 22'h3FFFFF, 1'b0);
        check(v == x, "R2 slow count", v, x);
        repeat (70) @(negedge clk);
        read_count(25, v, r);
        x = exp_count(e, r, 22'h3FFFFF, 1'b0);
        check(v == x, "R5 snapshot across gap", v, x);
    endtask

    task automatic t_fast();
        int e, v, r, x;
        bus_write(3'd0, 8'h00);
        speed_sel = 1'b1;
        bus_write(3'd0, 8'h01);
        e = cyc;
        repeat (41) @(negedge clk);
        read_count(3, v, r);
        x = exp_count(e, r, 22'h3FFFFF, 1'b1);
        check(v == x, "R3 fast count", v, x);
        repeat (200) @(negedge clk);
        read_count(30, v, r);
        x = exp_count(e, r, 22'h3FFFFF, 1'b1);
        check(v == x, "R3 fast count later", v, x);
        bus_write(3'd0, 8'h00);
        speed_sel = 1'b0;
    endtask

    task automatic t_wrap();
        int e, v, r, x;
        bus_write(3'd0, 8'h00);
        write_term(9);
        bus_write(3'd0, 8'h01);
        e = cyc;
        for (int i = 0; i < 4; i++) begin
            repeat (i * 7 + 3) @(negedge clk);
            read_count(i, v, r);
            x = exp_count(e, r, 9, 1'b0);
            check(v == x, "R4 wrap at terminal 9", v, x);
        end
        bus_write(3'd0, 8'h00);
        write_term(0);
        bus_write(3'd0, 8'h01);
        repeat (15) @(negedge clk);
        read_count(0, v, r);
        check(v == 0, "R4 terminal zero holds count", v, 0);
    endtask

    task automatic t_freeze();
        int a, b, r;
        bus_write(3'd0, 8'h00);
        write_term(22'h3FFFFF);
        bus_write(3'd0, 8'h01);
        repeat (30) @(negedge clk);
        bus_write(3'd0, 8'h00);
        read_count(0, a, r);
        repeat (50) @(negedge clk);
        read_count(0, b, r);
        check(a == b && a > 30, "R8 halted count constant", b, a);
        bus_write(3'd1, 8'hFF);
        read_count(0, b, r);
        check(b == 0, "R9 terminal write while halted clears", b, 0);
    endtask

    task automatic t_irq();
        int e, f, f2, f3;
        bus_write(3'd0, 8'h00);
        write_term(19);
        bus_write(3'd0, 8'h02);
        bus_write(3'd0, 8'h03);
        e = cyc;
        wait_irq(f);
        check(f == e + 21, "R10 first irq edge", f, e + 21);
        bus_write(3'd0, 8'h01);
        check(irq == 1'b0, "R11 irq drops on ie clear", irq, 0);
        bus_write(3'd0, 8'h03);
        check(irq == 1'b0, "R11 no irq after ie re-set", irq, 0);
        wait_irq(f2);
        check(f2 == f + 20, "R10 irq on next wrap", f2, f + 20);
        bus_write(3'd0, 8'h01);
        repeat (70) @(negedge clk);
        bus_write(3'd0, 8'h03);
        check(irq == 1'b0, "R10 masked wraps leave nothing pending", irq, 0);
        wait_irq(f3);
        check((f3 - e - 1) % 20 == 0, "R10 irq aligned to wrap", (f3 - e - 1) % 20, 0);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_long();
        int e, v, r, x;
        bus_write(3'd0, 8'h00);
        write_term(22'h3FFFFF);
        bus_write(3'd0, 8'h01);
        e = cyc;
        repeat (134000) @(negedge clk);
        read_count(5, v, r);
        x = exp_count(e, r, 22'h3FFFFF, 1'b0);
        check(v == x && v[17] == 1'b1, "R6 high count field layout", v, x);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_slow();
        t_fast();
        t_wrap();
        t_freeze();
        t_irq();
        t_long();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule